// File: doc/BRIEF.md
# Tagged Weighted Pooling Accumulator

This block is the arithmetic core that sits beside one memory rank in an embedding-lookup engine. A stream of embedding vector elements arrives one per cycle. Each element carries a small pooling tag and an element index. The tag separates several reductions that run interleaved in the same stream. Each element may first be dequantized with a per-row scale and offset. It is then scaled by a per-lookup weight and added into the partial-sum register picked by its tag and index.

Plain sums, weighted sums and quantized sums all use one datapath. When a mode is off, the unused coefficient is replaced by its neutral value. All arithmetic is signed fixed point and clamps at the accumulator range instead of wrapping. The host loads an element budget before a packet. Each accepted element uses up one unit of that budget. Once the budget is spent and every element has reached its register, the block raises `done`, and the host reads the sums one element at a time.

Top module: `pool_accum`

## Requirements
- R1: Each accepted element contributes T = floor(floor(e·s / 2^FRAC + b) · w / 2^FRAC), computed as follows:
  - e and b are signed 8-bit integers.
  - s and w are signed 8-bit values with FRAC = 4 fraction bits, so the code 16 means 1.0.
  - Each floor is an arithmetic shift toward minus infinity.
- R2: While `weighted_en` is 0, the weight is taken as 1.0 (code 16), and `in_weight` has no effect on any sum.
- R3: While `quant_en` is 0, the scale is taken as 1.0 (code 16) and the offset as 0, and `in_scale` and `in_bias` have no effect.
- R4: The accumulator updated is the one at tag `in_tag` (4 bits, 16 tags) and element `in_idx` (2 bits, 4 elements). No other accumulator changes.
- R5: Elements aimed at the same accumulator on consecutive cycles are all summed, and none is lost.
- R6: Both the term T and each running sum are clamped to the signed 16-bit range [-32768, 32767].
- R7: The element budget is loaded by `cfg_load` with `cfg_count`. Each element accepted while the budget is non-zero lowers it by one. Elements presented while it is zero are ignored.
- R8: An element accepted at a clock edge is visible in its accumulator 7 edges later. `done` is 1 exactly when the budget is zero and no accepted element is still in flight.
- R9: A pulse on `clr` sets every accumulator to zero.
- R10: A read request at one edge returns the addressed accumulator on `rd_data`, with `rd_valid` high, after that edge.
- R11: After reset, all accumulators are zero, the budget is zero and `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Zero all accumulators |
| cfg_load | input | 1 | Load the element budget |
| cfg_count | input | 16 | Budget value to load |
| in_valid | input | 1 | Element present |
| in_tag | input | 4 | Pooling tag |
| in_idx | input | 2 | Element index within the vector |
| in_elem | input | 8 | Signed embedding element |
| in_scale | input | 8 | Signed dequantization scale, 4 fraction bits |
| in_bias | input | 8 | Signed dequantization offset |
| in_weight | input | 8 | Signed weight, 4 fraction bits |
| weighted_en | input | 1 | Use `in_weight` |
| quant_en | input | 1 | Use `in_scale` and `in_bias` |
| done | output | 1 | Budget spent and pipeline empty |
| rd_en | input | 1 | Read request |
| rd_tag | input | 4 | Tag to read |
| rd_idx | input | 2 | Element to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Signed accumulator value |

## Verification
Each result has a fixed time after its stimulus:
- A sum reflects an element 7 edges after acceptance: 4 in the term pipeline and 3 in the add pipeline.
- `done` falls on the edge after acceptance and rises on the 7th.
- Read data appears 1 edge after the request.

The bench drives on falling edges and samples on falling edges. It counts edges explicitly for the `done` timing test. It reads sums back only after `done` is high, so every check lands after its result is due.

// File: rtl/pool_pkg.sv
package pool_pkg;

  // Clamp a wide signed value to the range of a w-bit signed number.
  function automatic logic signed [63:0] clamp_to(input logic signed [63:0] v, input int w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/pool_term_pipe.sv
module pool_term_pipe
  import pool_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int FRAC   = 4,
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 6,
  parameter int LAT    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fire,
  input  logic [ADDR_W-1:0]        addr,
  input  logic signed [DATA_W-1:0] elem,
  input  logic signed [COEF_W-1:0] scale,
  input  logic signed [COEF_W-1:0] bias,
  input  logic signed [COEF_W-1:0] weight,
  input  logic                     weighted_en,
  input  logic                     quant_en,
  output logic                     out_v,
  output logic [ADDR_W-1:0]        out_addr,
  output logic signed [ACC_W-1:0]  out_term,
  output logic                     busy
);

  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1 << FRAC);

  function automatic logic signed [ACC_W-1:0] calc_term(
    input logic signed [DATA_W-1:0] e,
    input logic signed [COEF_W-1:0] s,
    input logic signed [COEF_W-1:0] b,
    input logic signed [COEF_W-1:0] w);
    logic signed [63:0] e64, s64, b64, w64, deq, prod, c;
    e64  = e;
    s64  = s;
    b64  = b;
    w64  = w;
    deq  = ((e64 * s64) >>> FRAC) + b64;
    prod = (deq * w64) >>> FRAC;
    c    = clamp_to(prod, ACC_W);
    return c[ACC_W-1:0];
  endfunction

  logic signed [COEF_W-1:0] eff_scale, eff_bias, eff_weight;
  logic signed [ACC_W-1:0]  term_now;

  assign eff_scale  = quant_en    ? scale  : UNITY;
  assign eff_bias   = quant_en    ? bias   : '0;
  assign eff_weight = weighted_en ? weight : UNITY;
  assign term_now   = calc_term(elem, eff_scale, eff_bias, eff_weight);

  logic                    sv [LAT];
  logic [ADDR_W-1:0]       sa [LAT];
  logic signed [ACC_W-1:0] st [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sv[0] <= 1'b0;
          sa[0] <= '0;
          st[0] <= '0;
        end else begin
          sv[0] <= fire;
          sa[0] <= addr;
          st[0] <= term_now;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sv[i] <= 1'b0;
          sa[i] <= '0;
          st[i] <= '0;
        end else begin
          sv[i] <= sv[i-1];
          sa[i] <= sa[i-1];
          st[i] <= st[i-1];
        end
      end
      // R8
      stage_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sv[i-1] |=> sv[i]);
    end
  end

  always_comb begin
    busy = 1'b0;
    for (int i = 0; i < LAT; i++) busy = busy | sv[i];
  end

  assign out_v    = sv[LAT-1];
  assign out_addr = sa[LAT-1];
  assign out_term = st[LAT-1];

endmodule

// File: rtl/pool_acc_bank.sv
module pool_acc_bank
  import pool_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 6,
  parameter int LAT    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    in_v,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic signed [ACC_W-1:0] in_term,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    rd_valid,
  output logic signed [ACC_W-1:0] rd_data,
  output logic                    busy
);

  localparam int DEPTH = 1 << ADDR_W;

  logic signed [ACC_W-1:0] acc [DEPTH];
  logic                    av  [LAT];
  logic [ADDR_W-1:0]       aa  [LAT];
  logic signed [ACC_W-1:0] at  [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_add
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        av[i] <= 1'b0;
        aa[i] <= '0;
        at[i] <= '0;
      end else if (i == 0) begin
        av[i] <= in_v;
        aa[i] <= in_addr;
        at[i] <= in_term;
      end else begin
        av[i] <= av[(i == 0) ? 0 : i-1];
        aa[i] <= aa[(i == 0) ? 0 : i-1];
        at[i] <= at[(i == 0) ? 0 : i-1];
      end
    end
  end

  // The final add stage reads the register after any earlier write has landed.
  logic                    wr_en;
  logic [ADDR_W-1:0]       wr_addr;
  logic signed [ACC_W-1:0] wr_sum;
  logic signed [63:0]      cur64, add64, sum64;

  assign wr_en   = av[LAT-1];
  assign wr_addr = aa[LAT-1];

  always_comb begin
    cur64  = acc[wr_addr];
    add64  = at[LAT-1];
    sum64  = clamp_to(cur64 + add64, ACC_W);
    wr_sum = sum64[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) acc[k] <= '0;
    end else if (clr) begin
      for (int k = 0; k < DEPTH; k++) acc[k] <= '0;
    end else if (wr_en) begin
      acc[wr_addr] <= wr_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= acc[rd_addr];
    end
  end

  logic acc_nonzero;
  always_comb begin
    busy        = 1'b0;
    acc_nonzero = 1'b0;
    for (int i = 0; i < LAT; i++) busy = busy | av[i];
    for (int k = 0; k < DEPTH; k++) acc_nonzero = acc_nonzero | (acc[k] != '0);
  end

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !acc_nonzero);

  // R10
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

endmodule

// File: rtl/pool_accum.sv
module pool_accum #(
  parameter int NTAG    = 16,
  parameter int VLEN    = 4,
  parameter int DATA_W  = 8,
  parameter int COEF_W  = 8,
  parameter int FRAC    = 4,
  parameter int ACC_W   = 16,
  parameter int CNT_W   = 16,
  parameter int MUL_LAT = 4,
  parameter int ADD_LAT = 3,
  localparam int TAG_W  = $clog2(NTAG),
  localparam int IDX_W  = $clog2(VLEN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     cfg_load,
  input  logic [CNT_W-1:0]         cfg_count,
  input  logic                     in_valid,
  input  logic [TAG_W-1:0]         in_tag,
  input  logic [IDX_W-1:0]         in_idx,
  input  logic signed [DATA_W-1:0] in_elem,
  input  logic signed [COEF_W-1:0] in_scale,
  input  logic signed [COEF_W-1:0] in_bias,
  input  logic signed [COEF_W-1:0] in_weight,
  input  logic                     weighted_en,
  input  logic                     quant_en,
  output logic                     done,
  input  logic                     rd_en,
  input  logic [TAG_W-1:0]         rd_tag,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic                     rd_valid,
  output logic signed [ACC_W-1:0]  rd_data
);

  localparam int ADDR_W = TAG_W + IDX_W;

  logic [CNT_W-1:0] budget;
  logic             in_fire;
  logic             term_busy, add_busy;
  logic             t_v;
  logic [ADDR_W-1:0] t_addr;
  logic signed [ACC_W-1:0] t_term;

  assign in_fire = in_valid && (budget != '0) && !cfg_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         budget <= '0;
    else if (cfg_load)  budget <= cfg_count;
    else if (in_fire)   budget <= budget - 1'b1;
  end

  pool_term_pipe #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(FRAC),
    .ACC_W(ACC_W), .ADDR_W(ADDR_W), .LAT(MUL_LAT)
  ) u_term (
    .clk(clk), .rst_n(rst_n), .fire(in_fire),
    .addr({in_tag, in_idx}), .elem(in_elem), .scale(in_scale),
    .bias(in_bias), .weight(in_weight),
    .weighted_en(weighted_en), .quant_en(quant_en),
    .out_v(t_v), .out_addr(t_addr), .out_term(t_term), .busy(term_busy)
  );

  pool_acc_bank #(
    .ACC_W(ACC_W), .ADDR_W(ADDR_W), .LAT(ADD_LAT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .in_v(t_v), .in_addr(t_addr), .in_term(t_term),
    .rd_en(rd_en), .rd_addr({rd_tag, rd_idx}),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(add_busy)
  );

  assign done = (budget == '0) && !term_busy && !add_busy;

  // R7
  ignore_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && budget == '0 && !cfg_load) |=> (budget == '0));

  // R8
  busy_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> !done);

  // R8
  term_reaches_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_v |=> add_busy);

endmodule

// File: tb/sim_pool_accum.sv
module sim_pool_accum;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic cfg_load = 1'b0;
  logic [15:0] cfg_count = '0;
  logic in_valid = 1'b0;
  logic [3:0] in_tag = '0;
  logic [1:0] in_idx = '0;
  logic signed [7:0] in_elem = '0, in_scale = '0, in_bias = '0, in_weight = '0;
  logic weighted_en = 1'b0, quant_en = 1'b0;
  logic done;
  logic rd_en = 1'b0;
  logic [3:0] rd_tag = '0;
  logic [1:0] rd_idx = '0;
  logic rd_valid;
  logic signed [15:0] rd_data;

  always #4 clk = ~clk;

  pool_accum u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_load(cfg_load), .cfg_count(cfg_count),
    .in_valid(in_valid), .in_tag(in_tag), .in_idx(in_idx), .in_elem(in_elem),
    .in_scale(in_scale), .in_bias(in_bias), .in_weight(in_weight),
    .weighted_en(weighted_en), .quant_en(quant_en), .done(done),
    .rd_en(rd_en), .rd_tag(rd_tag), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int errors = 0;
  int checks = 0;
  int bcnt = 0;
  longint expv [64];

  task automatic chk(input string req, input longint act, input longint want);
    checks++;
    if (act != want) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, want);
    end
  endtask

  function automatic longint floor16(input longint a);
    if (a >= 0) return a / 16;
    return -((-a + 15) / 16);
  endfunction

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint model_term(input int e, input int s, input int b, input int w,
                                        input bit wen, input bit qen);
    int ss, bb, ww;
    ss = qen ? s : 16;
    bb = qen ? b : 0;
    ww = wen ? w : 16;
    return sat16(floor16(longint'(floor16(longint'(e) * ss) + bb) * ww));
  endfunction

  task automatic push(input int t, input int i, input int e, input int s, input int b, input int w);
    in_valid  = 1'b1;
    in_tag    = 4'(t);
    in_idx    = 2'(i);
    in_elem   = 8'(e);
    in_scale  = 8'(s);
    in_bias   = 8'(b);
    in_weight = 8'(w);
    if (bcnt > 0) begin
      expv[t*4+i] = sat16(expv[t*4+i] + model_term(e, s, b, w, weighted_en, quant_en));
      bcnt--;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
  endtask

  task automatic load(input int n);
    cfg_load  = 1'b1;
    cfg_count = 16'(n);
    @(negedge clk);
    cfg_load = 1'b0;
    bcnt = n;
  endtask

  task automatic clear_all();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    for (int k = 0; k < 64; k++) expv[k] = 0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 50 && !done; n++) @(negedge clk);
  endtask

  task automatic read_one(input string req, input int t, input int i);
    rd_en  = 1'b1;
    rd_tag = 4'(t);
    rd_idx = 2'(i);
    @(negedge clk);
    rd_en = 1'b0;
    chk({req, " rd_valid R10"}, longint'(rd_valid), 1);
    chk(req, longint'(rd_data), expv[t*4+i]);
  endtask

  task automatic read_all(input string req);
    for (int t = 0; t < 16; t++)
      for (int i = 0; i < 4; i++) read_one(req, t, i);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) expv[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 done after reset", longint'(done), 1);
    read_all("R11 reset zero");

    // R1 R2 R3 R4: sweep all modes over every tag and element
    for (int m = 0; m < 4; m++) begin
      clear_all();
      weighted_en = m[0];
      quant_en    = m[1];
      load(128);
      for (int rep = 0; rep < 2; rep++)
        for (int t = 0; t < 16; t++)
          for (int i = 0; i < 4; i++)
            push(t, i, int'($urandom_range(40)) - 20, int'($urandom_range(255)) - 128,
                 int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128);
      idle();
      wait_done();
      chk("R7 done after budget", longint'(done), 1);
      if (m == 0) read_all("R2 R3 plain sum");
      else if (m == 1) read_all("R1 R3 weighted sum");
      else if (m == 2) read_all("R1 R2 quantized sum");
      else read_all("R1 R4 weighted quantized sum");
    end

    // R5 back-to-back updates to one accumulator
    clear_all();
    weighted_en = 1'b0;
    quant_en    = 1'b0;
    load(8);
    for (int n = 1; n <= 8; n++) push(5, 2, n, 0, 0, 0);
    idle();
    wait_done();
    read_one("R5 back-to-back", 5, 2);
    chk("R5 expected total", expv[5*4+2], 36);
    read_one("R4 neighbour untouched", 5, 3);

    // R6 saturation in both directions
    clear_all();
    weighted_en = 1'b1;
    quant_en    = 1'b1;
    load(12);
    for (int n = 0; n < 6; n++) push(3, 1, 127, 127, 127, 127);
    for (int n = 0; n < 6; n++) push(3, 2, -128, 127, -128, 127);
    idle();
    wait_done();
    read_one("R6 high clamp", 3, 1);
    chk("R6 high value", expv[3*4+1], 32767);
    read_one("R6 low clamp", 3, 2);
    chk("R6 low value", expv[3*4+2], -32768);

    // R7 elements beyond the budget are ignored
    clear_all();
    weighted_en = 1'b0;
    quant_en    = 1'b0;
    load(3);
    for (int n = 0; n < 5; n++) push(7, 0, 10, 0, 0, 0);
    idle();
    wait_done();
    read_one("R7 ignore when empty", 7, 0);
    chk("R7 expected total", expv[7*4+0], 30);

    // R8 done timing and result latency
    load(1);
    chk("R8 done low with budget", longint'(done), 0);
    push(9, 3, 11, 0, 0, 0);
    idle();
    repeat (6) @(negedge clk);
    chk("R8 done still low at edge 6", longint'(done), 0);
    @(negedge clk);
    chk("R8 done high at edge 7", longint'(done), 1);
    read_one("R8 result landed", 9, 3);

    // R9 clear zeroes everything
    clear_all();
    read_all("R9 clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule